// File: doc/BRIEF.md
# External Interrupt Vector Priority Resolver

This block holds one pending flag and one in-service flag for each of the 256 interrupt vectors (0 to 255). It decides which vector the core should take next. A request port marks a vector as pending. An acknowledge moves the reported vector from pending to in-service. An end-of-interrupt strobe retires the most important in-service vector. Every cycle the block picks the most important pending vector. It then tests that vector against a software mask class, a global mask-all bit and the level of the most important in-service interrupt.

Priority does not follow plain numeric order. Vectors below 16 form a special group that ranks above all vectors from 16 to 255. Inside the special group, vector 2 (the non-maskable vector) ranks first and the other special vectors follow in descending numeric order. From 16 upward, a larger number means a higher priority. The top four bits of such a vector form its priority class. Vector 15 is never an interrupt. It is the code that means "nothing deliverable", and the output shows it whenever the best pending vector is blocked or nothing is pending.

Top module: `irq_vec_resolver`

## Requirements
- R1: During and after reset, no vector is pending or in service, the mask class is 0, mask-all is clear, and `vec_out` reads 15.
- R2: A request for vector V is taken at the clock edge where `req_valid` is high. V appears on `vec_out` at the following edge, if it is the best deliverable vector.
- R3: Among pending vectors from 16 to 255, the larger vector number is reported first.
- R4: Any pending vector below 16 outranks every vector from 16 to 255. Among vectors below 16, vector 2 ranks first and the rest rank in descending numeric order.
- R5: A vector of 16 or above whose class (bits [7:4]) is at or below the registered `mask_cls` is masked. If it is the best pending vector, the output is 15. A mask class of 15 masks every vector from 16 to 255.
- R6: While `mask_all` is set, every vector except vector 2 is blocked.
- R7: A vector can only be reported when its level is strictly above the level of the highest in-service interrupt. For vectors of 16 or above, the level is the class. Vectors below 16 sit above every class and are ranked as in R4. An equal class is blocked.
- R8: A pending vector 2 is reported whatever the mask settings and the in-service state.
- R9: An acknowledge while `vec_out` is not 15 clears that vector's pending flag and sets its in-service flag at the same edge. A request for the same vector at that edge keeps it pending.
- R10: An acknowledge while `vec_out` reads 15 leaves all pending and in-service flags unchanged.
- R11: End-of-interrupt clears only the in-service flag of the most important in-service vector, ranked as in R4. With nothing in service it has no effect.
- R12: A request for vector 15 is ignored.
- R13: The mask inputs are registered. A mask change reaches `vec_out` one edge after it is captured, which is the same latency that requests, acknowledges and end-of-interrupt have.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe for `req_vec` |
| req_vec | input | 8 | Vector being requested |
| ack | input | 1 | Accept the vector currently on `vec_out` |
| eoi | input | 1 | Retire the most important in-service vector |
| mask_cls | input | 4 | Mask threshold class |
| mask_all | input | 1 | Block everything except vector 2 |
| vec_out | output | 8 | Registered best deliverable vector, or 15 |

## Verification
The bench builds two instances with the default 8-bit vector width. One uses the log-depth comparison tree and the other uses the linear scan picker. Both receive the same stimulus, and every check compares each output against the same expected value, so both picker variants and the ranking key they share are exercised. The default width covers the full 0 to 255 range. This brings the special group, the mask class limits 0 and 15, and equal-class nesting within reach.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
   localparam int unsigned VEC_W = 8;
   localparam int unsigned CLS_W = 4;
   localparam int unsigned KEY_W = VEC_W + 1;
   localparam int unsigned LVL_W = CLS_W + 1;

   typedef logic [VEC_W-1:0] vec_t;
   typedef logic [CLS_W-1:0] cls_t;
   typedef logic [KEY_W-1:0] key_t;
   typedef logic [LVL_W-1:0] lvl_t;

   localparam vec_t SPECIAL_LIM = vec_t'(16);
   localparam vec_t NMI_VEC     = vec_t'(2);
   localparam vec_t IDLE_VEC    = vec_t'(15);

   function automatic cls_t class_of(vec_t v);
      return v[VEC_W-1 -: CLS_W];
   endfunction

   function automatic logic [CLS_W-1:0] special_rank(vec_t v);
      return (v == NMI_VEC) ? {CLS_W{1'b1}} : v[CLS_W-1:0];
   endfunction

   // Total order: larger key wins
   function automatic key_t prio_key(vec_t v);
      if (v < SPECIAL_LIM)
         return {1'b1, {(VEC_W-CLS_W){1'b0}}, special_rank(v)};
      return {1'b0, v};
   endfunction

   // Nesting level: class for normal vectors, above all classes for specials
   function automatic lvl_t level_of(vec_t v);
      if (v < SPECIAL_LIM)
         return {1'b1, special_rank(v)};
      return {1'b0, class_of(v)};
   endfunction
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_res_pkg::*;
#(
   parameter int unsigned N        = 256,
   parameter bit          USE_TREE = 1'b1
)(
   input  logic [N-1:0] set_i,
   output logic         found_o,
   output vec_t         vec_o
);
   localparam int unsigned NODES = 2 * N;

   if (N < 2 || N > (1 << VEC_W) || (N & (N - 1)) != 0) begin : g_bad_n
      $error("irq_prio_pick: N must be a power of two within the vector space");
   end

   if (USE_TREE) begin : g_tree
      logic node_v   [1:NODES-1];
      vec_t node_vec [1:NODES-1];

      for (genvar i = 0; i < N; i++) begin : g_leaf
         assign node_v[N+i]   = set_i[i];
         assign node_vec[N+i] = vec_t'(i);
      end

      for (genvar j = 1; j < N; j++) begin : g_node
         logic take_hi;
         assign take_hi = node_v[2*j+1] &&
                          (!node_v[2*j] ||
                           (prio_key(node_vec[2*j+1]) > prio_key(node_vec[2*j])));
         assign node_v[j]   = node_v[2*j] | node_v[2*j+1];
         assign node_vec[j] = take_hi ? node_vec[2*j+1] : node_vec[2*j];
      end

      assign found_o = node_v[1];
      assign vec_o   = node_vec[1];
   end else begin : g_linear
      always_comb begin
         found_o = 1'b0;
         vec_o   = '0;
         for (int k = 0; k < N; k++) begin
            if (set_i[k] && (!found_o || (prio_key(vec_t'(k)) > prio_key(vec_o)))) begin
               found_o = 1'b1;
               vec_o   = vec_t'(k);
            end
         end
      end
   end
endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state
   import irq_res_pkg::*;
#(
   parameter int unsigned N = 256
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  vec_t         req_vec,
   input  logic         ack_fire,
   input  vec_t         ack_vec,
   input  logic         eoi,
   input  logic         isv_found,
   input  vec_t         isv_top,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] isv_o
);
   logic [N-1:0] pend_q, pend_d;
   logic [N-1:0] isv_q, isv_d;

   // Order matters: clears first, then sets, so a same-edge set wins
   always_comb begin
      pend_d = pend_q;
      isv_d  = isv_q;
      if (eoi && isv_found)
         isv_d[isv_top] = 1'b0;
      if (ack_fire) begin
         pend_d[ack_vec] = 1'b0;
         isv_d[ack_vec]  = 1'b1;
      end
      if (req_valid && (req_vec != IDLE_VEC))
         pend_d[req_vec] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         isv_q  <= '0;
      end else begin
         pend_q <= pend_d;
         isv_q  <= isv_d;
      end
   end

   assign pend_o = pend_q;
   assign isv_o  = isv_q;

   // R9
   ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire && !(req_valid && req_vec == ack_vec)
      |=> isv_q[$past(ack_vec)] && !pend_q[$past(ack_vec)]);

   // R12
   idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_vec == IDLE_VEC |=> !pend_q[IDLE_VEC]);

   // R11
   eoi_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoi && isv_found && !(ack_fire && ack_vec == isv_top)
      |=> !isv_q[$past(isv_top)]);
endmodule

// File: rtl/irq_deliver_gate.sv
module irq_deliver_gate
   import irq_res_pkg::*;
(
   input  logic pend_found,
   input  vec_t pend_vec,
   input  logic isv_found,
   input  vec_t isv_vec,
   input  cls_t mask_cls,
   input  logic mask_all,
   output logic deliver_ok
);
   logic is_nmi, is_special, above_isv, unmasked;

   always_comb begin
      is_nmi     = (pend_vec == NMI_VEC);
      is_special = (pend_vec < SPECIAL_LIM);
      above_isv  = !isv_found || (level_of(pend_vec) > level_of(isv_vec));
      if (mask_all)
         unmasked = 1'b0;
      else if (is_special)
         unmasked = 1'b1;
      else
         unmasked = class_of(pend_vec) > mask_cls;
      deliver_ok = pend_found && (is_nmi || (above_isv && unmasked));
   end
endmodule

// File: rtl/irq_vec_resolver.sv
module irq_vec_resolver
   import irq_res_pkg::*;
#(
   parameter int unsigned VEC_BITS = 8,
   parameter bit          USE_TREE = 1'b1
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [VEC_BITS-1:0] req_vec,
   input  logic                ack,
   input  logic                eoi,
   input  logic [3:0]          mask_cls,
   input  logic                mask_all,
   output logic [VEC_BITS-1:0] vec_out
);
   localparam int unsigned N = 1 << VEC_BITS;

   if (VEC_BITS != VEC_W) begin : g_bad_w
      $error("irq_vec_resolver: VEC_BITS must match the package vector width");
   end

   cls_t         mask_cls_q;
   logic         mask_all_q;
   logic [N-1:0] pend, isv;
   logic         pend_found, isv_found, deliver_ok, ack_fire;
   vec_t         pend_best, isv_best;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_cls_q <= '0;
         mask_all_q <= 1'b0;
      end else begin
         mask_cls_q <= mask_cls;
         mask_all_q <= mask_all;
      end
   end

   assign ack_fire = ack && (vec_out != IDLE_VEC);

   irq_vec_state #(.N(N)) u_state (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_vec   (req_vec),
      .ack_fire  (ack_fire),
      .ack_vec   (vec_out),
      .eoi       (eoi),
      .isv_found (isv_found),
      .isv_top   (isv_best),
      .pend_o    (pend),
      .isv_o     (isv)
   );

   irq_prio_pick #(.N(N), .USE_TREE(USE_TREE)) u_pick_pend (
      .set_i   (pend),
      .found_o (pend_found),
      .vec_o   (pend_best)
   );

   irq_prio_pick #(.N(N), .USE_TREE(USE_TREE)) u_pick_isv (
      .set_i   (isv),
      .found_o (isv_found),
      .vec_o   (isv_best)
   );

   irq_deliver_gate u_gate (
      .pend_found (pend_found),
      .pend_vec   (pend_best),
      .isv_found  (isv_found),
      .isv_vec    (isv_best),
      .mask_cls   (mask_cls_q),
      .mask_all   (mask_all_q),
      .deliver_ok (deliver_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         vec_out <= IDLE_VEC;
      else
         vec_out <= deliver_ok ? pend_best : IDLE_VEC;
   end

   // R8
   nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[NMI_VEC] |=> vec_out == NMI_VEC);

   // R6
   mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_all_q && !pend[NMI_VEC] |=> vec_out == IDLE_VEC);

   // R5
   mask_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_out >= SPECIAL_LIM |-> class_of(vec_out) > $past(mask_cls_q));

   // R10
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack && vec_out == IDLE_VEC && !req_valid && !eoi |=> $stable(pend) && $stable(isv));
endmodule

// File: tb/irq_vec_resolver_tb.sv
module irq_vec_resolver_tb;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       req_valid, ack, eoi, mask_all;
   logic [7:0] req_vec;
   logic [3:0] mask_cls;
   logic [7:0] vo_tree, vo_lin;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   irq_vec_resolver #(.VEC_BITS(8), .USE_TREE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
      .ack(ack), .eoi(eoi), .mask_cls(mask_cls), .mask_all(mask_all),
      .vec_out(vo_tree)
   );

   irq_vec_resolver #(.VEC_BITS(8), .USE_TREE(1'b0)) u_dut_lin (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
      .ack(ack), .eoi(eoi), .mask_cls(mask_cls), .mask_all(mask_all),
      .vec_out(vo_lin)
   );

   task automatic check(input logic [7:0] exp, input string tag);
      n_chk++;
      if (vo_tree !== exp || vo_lin !== exp) begin
         n_bad++;
         $display("FAIL %s: tree=%0d linear=%0d expected=%0d", tag, vo_tree, vo_lin, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_vec = '0; ack = 1'b0; eoi = 1'b0;
      mask_cls = '0; mask_all = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic push(input logic [7:0] v);
      req_valid = 1'b1; req_vec = v;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic pulse_eoi();
      eoi = 1'b1;
      @(negedge clk);
      eoi = 1'b0;
   endtask

   task automatic set_mask(input logic [3:0] c, input logic all);
      mask_cls = c; mask_all = all;
      @(negedge clk);
   endtask

   task automatic expect_out(input logic [7:0] exp, input string tag);
      @(negedge clk);
      check(exp, tag);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; req_valid = 1'b0; req_vec = '0; ack = 1'b0; eoi = 1'b0;
      mask_cls = '0; mask_all = 1'b0;
      repeat (2) @(negedge clk);
      check(8'd15, "R1 in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(8'd15, "R1 after reset");
   endtask

   task automatic t_order_and_nesting();
      do_reset();
      push(8'h40);
      expect_out(8'h40, "R2 single request");
      push(8'h9A); push(8'h41);
      expect_out(8'h9A, "R3 larger vector wins");
      pulse_ack();
      expect_out(8'h15 - 8'h06, "R7 lower class blocked by in-service");
      push(8'hA0);
      expect_out(8'hA0, "R7 higher class nests");
      push(8'h95);
      pulse_ack();
      expect_out(8'd15, "R7 equal class blocked");
      pulse_eoi();
      expect_out(8'd15, "R11 eoi retires A0 only");
      pulse_eoi();
      expect_out(8'h95, "R11 second eoi retires 9A");
   endtask

   task automatic t_specials();
      do_reset();
      push(8'hFF); push(8'd5);
      expect_out(8'd5, "R4 special beats FF");
      push(8'd9);
      expect_out(8'd9, "R4 special descending order");
      push(8'd2); push(8'd0);
      expect_out(8'd2, "R4 vector 2 first");
      pulse_ack();
      expect_out(8'd15, "R7 specials below in-service 2");
      pulse_eoi();
      expect_out(8'd9, "R11 eoi retires 2");
   endtask

   task automatic t_masks();
      do_reset();
      set_mask(4'd5, 1'b0);
      push(8'h50);
      expect_out(8'd15, "R5 class equal to mask");
      push(8'h60);
      expect_out(8'h60, "R5 class above mask");
      set_mask(4'd6, 1'b0);
      expect_out(8'd15, "R13 mask change latency");
      set_mask(4'd14, 1'b0);
      push(8'hF1);
      expect_out(8'hF1, "R5 class 15 over mask 14");
      set_mask(4'd15, 1'b0);
      expect_out(8'd15, "R5 mask 15 blocks all");
      set_mask(4'd0, 1'b1);
      push(8'd7);
      expect_out(8'd15, "R6 mask_all blocks special 7");
      push(8'd2);
      expect_out(8'd2, "R6 vector 2 passes mask_all");
   endtask

   task automatic t_ack_rules();
      do_reset();
      set_mask(4'd3, 1'b0);
      push(8'h35);
      expect_out(8'd15, "R5 masked 35");
      pulse_ack();
      set_mask(4'd0, 1'b0);
      expect_out(8'h35, "R10 ack on idle ignored");
      pulse_ack();
      push(8'h34);
      expect_out(8'd15, "R9 35 now in service");
      pulse_eoi();
      expect_out(8'h34, "R9 35 left pending set");
   endtask

   task automatic t_nmi_override();
      do_reset();
      push(8'hF0);
      expect_out(8'hF0, "R2 F0 reported");
      pulse_ack();
      set_mask(4'd15, 1'b1);
      push(8'd2);
      expect_out(8'd2, "R8 vector 2 over in-service and masks");
   endtask

   task automatic t_idle_request();
      do_reset();
      push(8'd15);
      expect_out(8'd15, "R12 request 15 shows idle");
      push(8'h20);
      expect_out(8'h20, "R12 vector 15 never pending");
      pulse_eoi();
      push(8'h21);
      expect_out(8'h21, "R11 eoi with nothing in service");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_order_and_nesting();
      t_specials();
      t_masks();
      t_ack_rules();
      t_nmi_override();
      t_idle_request();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule